// File: doc/BRIEF.md
# PS/2 Keyboard Frame Receiver

This block takes the two open-collector lines of a PS/2 keyboard link, clock and data, and rebuilds the bytes the keyboard sends. Both lines are brought into the system clock domain through two-flop synchronisers. The data line is sampled whenever the synchronised clock line falls.

Each frame is checked for a start bit of 0, eight data bits, an odd parity bit and a stop bit of 1. A good byte is announced with a one-cycle strobe and is also pushed into a 16-entry circular queue. A consumer drains the queue through a pop input.

When the parity bit is wrong, the block drops the frame and strobes a request. That request asks a separate host-to-device transmitter to send the resend command byte. A watchdog abandons a half-received frame once the clock line has been quiet for 100 µs. A busy input holds off reception while another agent is using the shared lines.

Top module: `ps2_rx_frame`

## Requirements
- R1: After reset the queue is empty (`q_empty_o`=1), and `byte_vld_o` and `resend_o` are 0.
- R2: Both lines pass through a two-flop synchroniser, and one bit is taken per falling edge of the synchronised clock line. A frame is made of a start bit, eight data bits sent least-significant first, a parity bit and a stop bit.
- R3: While waiting for a start bit, a sampled 1 is discarded and the block keeps waiting. A following valid frame is received normally.
- R4: Parity is odd: the eight data bits and the parity bit together must hold an odd number of ones. On a mismatch the byte is dropped, the frame returns to idle, and `resend_o` pulses for one cycle. During that pulse `resend_byte_o` carries the command 0xFE.
- R5: A stop bit of 0 drops the byte with no strobe of any kind. The frame returns to idle whether the stop bit is 0 or 1.
- R6: The watchdog length is CLK_HZ/1e6 × TIMEOUT_US cycles, which is 12500 at the defaults. If that many cycles pass with no accepted falling edge, a partial frame is discarded. Every accepted edge restarts the count.
- R7: While `busy_i` is 1, falling edges are ignored, the frame returns to idle and the watchdog is cleared. No byte and no resend request come out.
- R8: Good bytes enter a circular queue of 2^DEPTH_LOG2 entries, 16 at the defaults, in arrival order. `q_data_o` shows the oldest entry. `pop_i` removes it when the queue is not empty. A byte that arrives while the queue is full is dropped, and the queue holds its contents.
- R9: `byte_vld_o` is a one-cycle pulse for each good byte, with the byte on `byte_o`. The pulse and the queue push happen at the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ps2_clk_i | input | 1 | PS/2 clock line (asynchronous) |
| ps2_dat_i | input | 1 | PS/2 data line (asynchronous) |
| busy_i | input | 1 | Lines in use by another agent; masks reception |
| pop_i | input | 1 | Remove the oldest queued byte |
| byte_vld_o | output | 1 | One-cycle strobe for a good byte |
| byte_o | output | 8 | Last good byte |
| resend_o | output | 1 | One-cycle request to send the resend command |
| resend_byte_o | output | 8 | Command byte for the transmitter (0xFE) |
| q_empty_o | output | 1 | Queue empty |
| q_data_o | output | 8 | Oldest queued byte |

## Verification
A wrong frame state or a misplaced sentinel becomes visible at the first stop bit that follows. It shows up as a missing or shifted byte, or as a spurious resend request, at most one frame after the fault. Watchdog and busy faults leave stale bits in the receive register, so the next frame decodes to the wrong value. Queue pointer faults show up on the same clock edge, either in `q_empty_o` or in the order of the bytes on `q_data_o`. Because the reference model is compared every cycle, each of these faults is flagged in the exact cycle where the outputs first diverge.

// File: rtl/ps2_rx_frame.sv
module ps2_rx_frame #(
  parameter int          CLK_HZ     = 125_000_000,
  parameter int          TIMEOUT_US = 100,
  parameter int          DEPTH_LOG2 = 4,
  parameter logic [7:0]  RESEND_CMD = 8'hFE
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ps2_clk_i,
  input  logic       ps2_dat_i,
  input  logic       busy_i,
  input  logic       pop_i,
  output logic       byte_vld_o,
  output logic [7:0] byte_o,
  output logic       resend_o,
  output logic [7:0] resend_byte_o,
  output logic       q_empty_o,
  output logic [7:0] q_data_o
);
  localparam int TO_CYC = (CLK_HZ / 1_000_000) * TIMEOUT_US;
  localparam int TW     = $clog2(TO_CYC);
  localparam int DEPTH  = 1 << DEPTH_LOG2;
  localparam int AW     = DEPTH_LOG2;

  typedef enum logic [1:0] {S_START, S_DATA, S_PAR, S_STOP} st_t;

  logic [2:0]    csync;
  logic [1:0]    dsync;
  st_t           st;
  logic [7:0]    sh;
  logic [TW-1:0] tmr;
  logic [AW:0]   wp, rp;
  logic [7:0]    mem [DEPTH];

  wire fall    = csync[2] & ~csync[1] & ~busy_i;
  wire bit_in  = dsync[1];
  wire expired = (tmr == TW'(TO_CYC - 1));
  wire full    = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  wire push    = fall && (st == S_STOP) && bit_in;

  assign q_empty_o     = (wp == rp);
  assign q_data_o      = mem[rp[AW-1:0]];
  assign resend_byte_o = RESEND_CMD;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csync <= '1;
      dsync <= '1;
    end else begin
      csync <= {csync[1:0], ps2_clk_i};
      dsync <= {dsync[0], ps2_dat_i};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_START;
      sh         <= '0;
      tmr        <= '0;
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
      resend_o   <= 1'b0;
    end else begin
      byte_vld_o <= 1'b0;
      resend_o   <= 1'b0;
      if (busy_i) begin
        st  <= S_START;
        tmr <= '0;
      end else if (fall) begin
        tmr <= '0;
        unique case (st)
          S_START: if (!bit_in) begin
            st <= S_DATA;
            sh <= 8'h80;
          end
          S_DATA: begin
            sh <= {bit_in, sh[7:1]};
            if (sh[0]) st <= S_PAR;
          end
          S_PAR: begin
            if (bit_in == ~^sh) st <= S_STOP;
            else begin
              st       <= S_START;
              resend_o <= 1'b1;
            end
          end
          S_STOP: begin
            st <= S_START;
            if (bit_in) begin
              byte_vld_o <= 1'b1;
              byte_o     <= sh;
            end
          end
        endcase
      end else if (expired) begin
        st <= S_START;
      end else begin
        tmr <= tmr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push && !full) begin
        mem[wp[AW-1:0]] <= sh;
        wp              <= wp + 1'b1;
      end
      if (pop_i && !q_empty_o) rp <= rp + 1'b1;
    end
  end
endmodule

// File: rtl/ps2_rx_frame_chk.sv
module ps2_rx_frame_chk (
  input logic clk,
  input logic rst_n,
  input logic busy_i,
  input logic pop_i,
  input logic byte_vld_o,
  input logic resend_o,
  input logic q_empty_o
);
  // R4
  resend_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resend_o |=> !resend_o);

  // R9
  vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld_o |=> !byte_vld_o);

  // R5
  vld_resend_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_vld_o && resend_o));

  // R7
  busy_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy_i) |-> (!byte_vld_o && !resend_o));

  // R9
  push_with_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(q_empty_o) |-> byte_vld_o);

  // R8
  empty_by_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_empty_o) |-> $past(pop_i));
endmodule

bind ps2_rx_frame ps2_rx_frame_chk chk_i (.*);

// File: tb/ps2_rx_frame_tb_top.sv
`timescale 1ns/1ps
module ps2_rx_frame_tb_top;
  localparam int TO_CYC = 12500;
  localparam int HALF   = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ps2_clk = 1'b1, ps2_dat = 1'b1, busy = 1'b0, pop = 1'b0;
  logic byte_vld, resend, q_empty;
  logic [7:0] byte_d, resend_byte, q_data;

  int total = 0, bad = 0, cyc = 0;
  int n_vld = 0, n_rs = 0;

  always #4 clk = ~clk;

  ps2_rx_frame dut_i (
    .clk(clk), .rst_n(rst_n), .ps2_clk_i(ps2_clk), .ps2_dat_i(ps2_dat),
    .busy_i(busy), .pop_i(pop), .byte_vld_o(byte_vld), .byte_o(byte_d),
    .resend_o(resend), .resend_byte_o(resend_byte), .q_empty_o(q_empty),
    .q_data_o(q_data)
  );

  // reference model
  int m_st, m_n, m_t;
  logic [7:0] m_acc, e_byte;
  logic e_vld, e_rs;
  logic c1, c2, c3, d1, d2;
  logic [7:0] mq[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_n = 0; m_t = 0; m_acc = 0; e_byte = 0;
      e_vld = 0; e_rs = 0;
      c1 = 1; c2 = 1; c3 = 1; d1 = 1; d2 = 1;
      mq.delete();
    end else begin
      int pre;
      pre = mq.size();
      e_vld = 0; e_rs = 0;
      if (busy) begin
        m_st = 0; m_t = 0;
      end else if (c3 && !c2) begin
        m_t = 0;
        case (m_st)
          0: if (!d2) begin m_st = 1; m_n = 0; m_acc = 0; end
          1: begin
            m_acc[m_n] = d2; m_n++;
            if (m_n == 8) m_st = 2;
          end
          2: if (($countones(m_acc) + int'(d2)) % 2 == 1) m_st = 3;
             else begin m_st = 0; e_rs = 1; end
          default: begin
            m_st = 0;
            if (d2) begin
              e_vld = 1; e_byte = m_acc;
              if (pre < 16) mq.push_back(m_acc);
            end
          end
        endcase
      end else if (m_t == TO_CYC - 1) m_st = 0;
      else m_t++;
      if (pop && pre > 0) void'(mq.pop_front());
      c3 = c2; c2 = c1; c1 = ps2_clk; d2 = d1; d1 = ps2_dat;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (byte_vld) n_vld++;
      if (resend) n_rs++;
      chk("R9 byte_vld", byte_vld, e_vld);
      chk("R9 byte_o", byte_d, e_byte);
      chk("R4 resend", resend, e_rs);
      chk("R8 q_empty", q_empty, mq.size() == 0);
      if (mq.size() > 0) chk("R8 q_data", q_data, mq[0]);
    end
    if (cyc > 200000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic send_bit(input logic b);
    @(negedge clk) ps2_dat = b;
    repeat (HALF) @(negedge clk);
    ps2_clk = 1'b0;
    repeat (HALF) @(negedge clk);
    ps2_clk = 1'b1;
  endtask

  task automatic send_frame(input logic [7:0] v, input logic par_ok, input logic stop);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
    send_bit(par_ok ? ~^v : ^v);
    send_bit(stop);
    @(negedge clk) ps2_dat = 1'b1;
    repeat (60) @(negedge clk);
  endtask

  task automatic pop_one();
    @(negedge clk) pop = 1'b1;
    @(negedge clk) pop = 1'b0;
  endtask

  initial begin
    int v0, r0, cnt;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 empty", q_empty, 1'b1);
    chk("R1 vld", byte_vld, 1'b0);
    chk("R1 resend", resend, 1'b0);

    // R2 basic frames
    v0 = n_vld;
    send_frame(8'h1C, 1, 1);
    send_frame(8'hF0, 1, 1);
    send_frame(8'h00, 1, 1);
    chk("R2 frames received", 8'(n_vld - v0), 8'd3);
    chk("R2 head byte", q_data, 8'h1C);

    // R3 stray 1 before start
    v0 = n_vld;
    send_bit(1'b1);
    send_frame(8'hA5, 1, 1);
    chk("R3 recovered frame", 8'(n_vld - v0), 8'd1);
    chk("R3 byte", byte_d, 8'hA5);

    // R4 parity error
    v0 = n_vld; r0 = n_rs;
    send_frame(8'h77, 0, 1);
    chk("R4 resend count", 8'(n_rs - r0), 8'd1);
    chk("R4 no byte", 8'(n_vld - v0), 8'd0);
    chk("R4 cmd", resend_byte, 8'hFE);

    // R5 bad stop bit
    v0 = n_vld; r0 = n_rs;
    send_frame(8'h3C, 1, 0);
    chk("R5 dropped", 8'(n_vld - v0), 8'd0);
    chk("R5 silent", 8'(n_rs - r0), 8'd0);
    send_frame(8'h42, 1, 1);
    chk("R5 back to idle", byte_d, 8'h42);

    // R6 watchdog discards partial frame
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    @(negedge clk) ps2_dat = 1'b1;
    repeat (TO_CYC + 50) @(negedge clk);
    v0 = n_vld;
    send_frame(8'h5A, 1, 1);
    chk("R6 after timeout", byte_d, 8'h5A);
    chk("R6 count", 8'(n_vld - v0), 8'd1);

    // R7 busy masks
    v0 = n_vld; r0 = n_rs;
    @(negedge clk) busy = 1'b1;
    send_frame(8'h99, 1, 1);
    send_frame(8'h99, 0, 1);
    @(negedge clk) busy = 1'b0;
    chk("R7 no byte", 8'(n_vld - v0), 8'd0);
    chk("R7 no resend", 8'(n_rs - r0), 8'd0);
    send_frame(8'h66, 1, 1);
    chk("R7 resumes", byte_d, 8'h66);

    // R8 drain, fill past capacity, drain
    while (!q_empty) pop_one();
    for (int i = 0; i < 18; i++) send_frame(8'(8'h10 + i), 1, 1);
    cnt = 0;
    while (!q_empty && cnt < 40) begin
      chk("R8 order", q_data, 8'(8'h10 + cnt));
      pop_one(); cnt++;
    end
    chk("R8 capacity", 8'(cnt), 8'd16);
    pop_one();
    chk("R8 pop on empty", q_empty, 1'b1);

    repeat (20) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule